// File: doc/BRIEF.md
# Compact 16-bit instruction decoder

This block turns one 16-bit instruction word of a small 32-bit CPU with sixteen general registers into the control fields that later stages use. The two top bits pick one of three layouts: a register-register layout with an 8-bit operation code, a register-immediate layout with a 2-bit operation and an unsigned byte, and a conditional-branch layout with a 4-bit condition and a 10-bit signed half-word displacement. Unused fields read as zero for each layout.

Besides the fields, the decoder reports the total instruction length (2 or 6 bytes) so that the fetch stage knows whether a 32-bit extension word follows. It also raises an illegal-instruction flag for unassigned codes and issues two write enables, one for the general register file and one for the special registers. The decoding is purely combinational. A parameter selects an optional output register stage, which is on by default and adds one clock of latency.

Top module: `instr_word_decoder`

## Requirements
- R1: `fmt_o` gives the layout class: 1 when bit 15 is 0, 2 when bits 15:14 are 10, 3 when bits 15:14 are 11.
- R2: For class 1, `op_o` is bits 15:8, `ra_o` is bits 7:4 and `rb_o` is bits 3:0. These are driven even when the code is illegal.
- R3: For class 2, `op_o` is bits 13:12 zero-extended, `ra_o` is bits 11:8 and `imm_o` is bits 7:0. Operation 0 adds the byte, 1 subtracts it, 2 copies special register number imm into `ra` and 3 copies `ra` into special register number imm.
- R4: For class 3, `op_o` is the condition in bits 13:10, zero-extended. `disp_o` is bits 9:0, sign-extended from 10 bits to 32 and then multiplied by two.
- R5: Outputs that do not belong to the current class are zero. `rb_o` is zero for classes 2 and 3, `ra_o` is zero for class 3, `imm_o` is zero outside class 2 and `disp_o` is zero outside class 3.
- R6: `len_o` is 6 and `ext_o` is 1 for the legal class 1 codes that carry an extension word: 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 to 0x39. For every other word, including illegal ones, `len_o` is 2 and `ext_o` is 0.
- R7: `illegal_o` is 1 for the class 1 codes 0x0F, 0x10 to 0x18 and 0x3A to 0x7F, and for class 3 conditions 0xA to 0xF. It is 0 for every other word, including every class 2 word.
- R8: `rf_we_o` is 1 for class 2 operations 0, 1 and 2. It is also 1 for class 1 codes 0x01, 0x02, 0x05, 0x08, 0x0A, 0x0C, 0x1B, 0x1C, 0x1D, 0x20, 0x21, 0x22, 0x26 to 0x2F, 0x31 to 0x34, 0x36 and 0x38. `sr_we_o` is 1 only for class 2 operation 3. Both enables are 0 for illegal words.
- R9: With the default register stage, every output reflects the word present at the previous rising clock edge. A synchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 16 | Instruction word |
| fmt_o | output | 2 | Layout class (1, 2, 3; 0 only after reset) |
| op_o | output | 8 | Operation code or condition |
| ra_o | output | 4 | First register index |
| rb_o | output | 4 | Second register index |
| imm_o | output | 8 | Unsigned immediate byte |
| disp_o | output | 32 | Sign-extended doubled branch displacement |
| len_o | output | 3 | Instruction length in bytes |
| ext_o | output | 1 | A 32-bit extension word follows |
| illegal_o | output | 1 | Unassigned code |
| rf_we_o | output | 1 | General register write enable |
| sr_we_o | output | 1 | Special register write enable |

## Verification
The decoder holds no state apart from the output stage, so a wrong table entry or field slice shows up at the ports one clock after the offending word is applied. It affects only the words that hit that entry. All 65536 words are applied in turn, so every opcode entry, every condition and every displacement bit is seen at least once. A fault in the gating of the enables or the length for illegal words appears as an enable or a 6-byte length next to a raised illegal flag. A fault in the output stage or its reset appears as outputs that are nonzero during reset or that lag by the wrong number of cycles.

// File: rtl/idec_pkg.sv
// Shared widths, class encoding and the decoded bundle for the
// instruction word decoder. Assumes a 16-bit word and 32-bit datapath.
package idec_pkg;
    localparam int IW     = 16;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 4;
    localparam int OPC_W  = 8;
    localparam int IMM_W  = 8;
    localparam int COND_W = 4;
    localparam int OFF_W  = 10;
    localparam int LEN_W  = 3;
    localparam int NUM_COND = 10;

    localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(2);
    localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(6);

    typedef enum logic [1:0] {
        FMT_NONE = 2'd0,
        FMT_REG  = 2'd1,
        FMT_IMM  = 2'd2,
        FMT_BRA  = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e              fmt;
        logic [OPC_W-1:0]  op;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rb;
        logic [IMM_W-1:0]  imm;
        logic [XLEN-1:0]   disp;
        logic [LEN_W-1:0]  len;
        logic              ext;
        logic              ill;
        logic              rf_we;
        logic              sr_we;
    } dec_t;
endpackage

// File: rtl/idec_regop.sv
// Attribute table for register-register class opcodes: whether the code
// is assigned, whether an extension word follows, and whether the result
// lands in the first register field. Assumes bit 7 of the code is 0.
module idec_regop
    import idec_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output logic             legal_o,
    output logic             ext_o,
    output logic             wr_o
);
    // Classify the opcode into its three attributes.
    always_comb begin
        legal_o = 1'b1;
        ext_o   = 1'b0;
        wr_o    = 1'b0;
        case (opc_i)
            8'h00, 8'h04, 8'h06, 8'h07, 8'h0B, 8'h0E, 8'h19,
            8'h1E, 8'h23, 8'h25, 8'h35:                 ;
            8'h01, 8'h08, 8'h0C, 8'h1B, 8'h1D, 8'h20,
            8'h22, 8'h36, 8'h38:                        begin ext_o = 1'b1; wr_o = 1'b1; end
            8'h03, 8'h09, 8'h0D, 8'h1A, 8'h1F, 8'h24,
            8'h30, 8'h37, 8'h39:                        ext_o = 1'b1;
            8'h02, 8'h05, 8'h0A, 8'h1C, 8'h21,
            8'h26, 8'h27, 8'h28, 8'h29, 8'h2A, 8'h2B,
            8'h2C, 8'h2D, 8'h2E, 8'h2F,
            8'h31, 8'h32, 8'h33, 8'h34:                 wr_o = 1'b1;
            default:                                    legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/idec_branch.sv
// Branch class helper: validates the condition code and builds the
// sign-extended, doubled displacement. Assumes OFF_W < XLEN.
module idec_branch
    import idec_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic              legal_o,
    output logic [XLEN-1:0]   disp_o
);
    localparam int SEXT_W = XLEN - OFF_W - 1;

    // Only the low NUM_COND condition codes are assigned.
    always_comb legal_o = (int'(cond_i) < NUM_COND);

    // Replicate the sign bit, then append a zero for half-word scaling.
    always_comb disp_o = {{SEXT_W{off_i[OFF_W-1]}}, off_i, 1'b0};
endmodule

// File: rtl/idec_stage.sv
// Optional output stage for the decoded bundle. REG_OUT=1 inserts one
// flop stage with synchronous active-low reset to all zeros; REG_OUT=0
// passes the bundle straight through.
module idec_stage
    import idec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  dec_t d_i,
    output dec_t q_o
);
    generate
        if (REG_OUT) begin : g_reg
            dec_t q_r;
            // Capture the bundle each edge; reset clears it.
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_pass
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/instr_word_decoder.sv
// Top of the 16-bit instruction decoder. Selects the layout from the two
// top bits, slices the fields, attaches length, legality and write
// enables, and forces the enables low for illegal words. Assumes the
// word is stable around the clock edge when REG_OUT is set.
module instr_word_decoder
    import idec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     instr_i,
    output logic [1:0]        fmt_o,
    output logic [OPC_W-1:0]  op_o,
    output logic [RIDX_W-1:0] ra_o,
    output logic [RIDX_W-1:0] rb_o,
    output logic [IMM_W-1:0]  imm_o,
    output logic [XLEN-1:0]   disp_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              ext_o,
    output logic              illegal_o,
    output logic              rf_we_o,
    output logic              sr_we_o
);
    logic            r_legal, r_ext, r_wr;
    logic            b_legal;
    logic [XLEN-1:0] b_disp;
    dec_t            dec_c, dec_q;

    idec_regop i_regop (
        .opc_i   (instr_i[15:8]),
        .legal_o (r_legal),
        .ext_o   (r_ext),
        .wr_o    (r_wr)
    );

    idec_branch i_branch (
        .cond_i  (instr_i[13:10]),
        .off_i   (instr_i[OFF_W-1:0]),
        .legal_o (b_legal),
        .disp_o  (b_disp)
    );

    // Assemble the bundle for the selected layout; unused fields stay zero.
    always_comb begin
        dec_c     = '0;
        dec_c.len = LEN_SHORT;
        case (instr_i[15:14])
            2'b10: begin
                dec_c.fmt   = FMT_IMM;
                dec_c.op    = OPC_W'(instr_i[13:12]);
                dec_c.ra    = instr_i[11:8];
                dec_c.imm   = instr_i[7:0];
                dec_c.rf_we = (instr_i[13:12] != 2'd3);
                dec_c.sr_we = (instr_i[13:12] == 2'd3);
            end
            2'b11: begin
                dec_c.fmt  = FMT_BRA;
                dec_c.op   = OPC_W'(instr_i[13:10]);
                dec_c.disp = b_disp;
                dec_c.ill  = !b_legal;
            end
            default: begin
                dec_c.fmt   = FMT_REG;
                dec_c.op    = instr_i[15:8];
                dec_c.ra    = instr_i[7:4];
                dec_c.rb    = instr_i[3:0];
                dec_c.ill   = !r_legal;
                dec_c.ext   = r_legal && r_ext;
                dec_c.len   = (r_legal && r_ext) ? LEN_LONG : LEN_SHORT;
                dec_c.rf_we = r_wr;
            end
        endcase
        if (dec_c.ill) begin
            dec_c.rf_we = 1'b0;
            dec_c.sr_we = 1'b0;
        end
    end

    idec_stage #(.REG_OUT(REG_OUT)) i_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dec_c),
        .q_o   (dec_q)
    );

    // Drive the ports from the (optionally registered) bundle.
    always_comb begin
        fmt_o     = dec_q.fmt;
        op_o      = dec_q.op;
        ra_o      = dec_q.ra;
        rb_o      = dec_q.rb;
        imm_o     = dec_q.imm;
        disp_o    = dec_q.disp;
        len_o     = dec_q.len;
        ext_o     = dec_q.ext;
        illegal_o = dec_q.ill;
        rf_we_o   = dec_q.rf_we;
        sr_we_o   = dec_q.sr_we;
    end

    // Illegal words never enable a write.
    p_ill_no_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !(rf_we_o || sr_we_o));

    // At most one write enable at a time.
    p_we_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we_o, sr_we_o}));

    // Special register writes come only from immediate-class operation 3.
    p_sr_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we_o |-> (fmt_o == 2'd2 && op_o == 8'd3));

    // The extension flag agrees with the 6-byte length.
    p_ext_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_o == (len_o == LEN_LONG));

    // Branch displacements are always half-word aligned.
    p_disp_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_o == 2'd3) |-> !disp_o[0]);

    // The immediate byte is zero outside the immediate class.
    p_imm_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_o != 2'd2) |-> (imm_o == '0));

    // Immediate-class words are always legal.
    p_imm_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_o == 2'd2) |-> !illegal_o);
endmodule

// File: tb/test_instr_word_decoder.sv
// Scoreboard bench: the driver applies every 16-bit word and queues the
// expected decode; the monitor pops and compares one clock later.
module test_instr_word_decoder;
    import idec_pkg::*;

    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'hFFFF;
    logic [1:0]  fmt;
    logic [7:0]  op, imm;
    logic [3:0]  ra, rb;
    logic [31:0] disp;
    logic [2:0]  len;
    logic        ext, ill, rf_we, sr_we;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    dec_t sb[$];
    dec_t cur;

    instr_word_decoder i_instr_word_decoder (
        .clk(clk), .rst_n(rst_n), .instr_i(instr),
        .fmt_o(fmt), .op_o(op), .ra_o(ra), .rb_o(rb), .imm_o(imm),
        .disp_o(disp), .len_o(len), .ext_o(ext), .illegal_o(ill),
        .rf_we_o(rf_we), .sr_we_o(sr_we)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference decode written from the requirements.
    function automatic dec_t model(logic [15:0] w);
        dec_t e;
        int   c;
        int   d;
        logic [7:0] o;
        e = '0;
        e.len = 3'd2;
        if (!w[15]) begin
            o = w[15:8];
            e.fmt = FMT_REG; e.op = o; e.ra = w[7:4]; e.rb = w[3:0];
            e.ill = (o == 8'h0F) || (o >= 8'h10 && o <= 8'h18) || (o >= 8'h3A);
            if (!e.ill && (o inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A,
                          8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22, 8'h24, 8'h30,
                          [8'h36:8'h39]})) begin
                e.len = 3'd6; e.ext = 1'b1;
            end
            e.rf_we = !e.ill && (o inside {8'h01, 8'h02, 8'h05, 8'h08, 8'h0A, 8'h0C,
                          8'h1B, 8'h1C, 8'h1D, 8'h20, 8'h21, 8'h22, [8'h26:8'h2F],
                          [8'h31:8'h34], 8'h36, 8'h38});
        end else if (!w[14]) begin
            e.fmt = FMT_IMM; e.op = {6'd0, w[13:12]}; e.ra = w[11:8]; e.imm = w[7:0];
            e.rf_we = (w[13:12] < 2'd3);
            e.sr_we = (w[13:12] == 2'd3);
        end else begin
            c = int'(w[13:10]);
            d = int'(w[9:0]);
            if (w[9]) d = d - 1024;
            e.fmt = FMT_BRA; e.op = 8'(c); e.disp = 32'(d * 2);
            e.ill = (c >= 10);
        end
        return e;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s instr=%h actual=%h expected=%h", tag, what, instr, act, exp);
        end
    endtask

    task automatic compare(dec_t e);
        string ftag;
        ftag = (e.fmt == FMT_REG) ? "R2" : (e.fmt == FMT_IMM) ? "R3" : "R4";
        chk("R1", "fmt", 32'(fmt), 32'(e.fmt));
        chk(ftag, "op", 32'(op), 32'(e.op));
        chk((e.fmt == FMT_BRA) ? "R5" : ftag, "ra", 32'(ra), 32'(e.ra));
        chk((e.fmt == FMT_REG) ? "R2" : "R5", "rb", 32'(rb), 32'(e.rb));
        chk((e.fmt == FMT_IMM) ? "R3" : "R5", "imm", 32'(imm), 32'(e.imm));
        chk((e.fmt == FMT_BRA) ? "R4" : "R5", "disp", disp, e.disp);
        chk("R6", "len", 32'(len), 32'(e.len));
        chk("R6", "ext", 32'(ext), 32'(e.ext));
        chk("R7", "illegal", 32'(ill), 32'(e.ill));
        chk("R8", "rf_we", 32'(rf_we), 32'(e.rf_we));
        chk("R8", "sr_we", 32'(sr_we), 32'(e.sr_we));
    endtask

    task automatic check_reset_zero(string when);
        chk("R9", {when, " all outputs zero"},
            32'({fmt, op, ra, rb, imm, len, ext, ill, rf_we, sr_we} != '0) | disp, 32'd0);
    endtask

    task automatic drive(logic [15:0] w);
        @(negedge clk);
        instr = w;
        sb.push_back(model(w));
    endtask

    // Monitor: the word applied before this edge appears after it.
    initial begin
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                cur = sb.pop_front();
                #(CLK_PERIOD/4);
                compare(cur);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R9: reset clears outputs even with an illegal branch word applied.
        repeat (3) @(negedge clk);
        check_reset_zero("initial reset");
        rst_n = 1'b1;
        // Exhaustive sweep of every word value.
        for (int i = 0; i < 65536; i++) drive(16'(i));
        repeat (3) @(negedge clk);
        // R9: a mid-run reset clears a nonzero decode.
        instr = 16'h8F37;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_zero("mid-run reset");
        rst_n = 1'b1;
        // R9: after release the next word shows one edge later.
        drive(16'hC3FF);
        drive(16'h0312);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule